// File: doc/BRIEF.md
# Interrupt-Capable General-Purpose Pin Controller

This block drives and samples 32 general-purpose pins through a small word-addressed register port. Each pin has an output value bit, an output-enable bit and a synchronised input level that software can read back. The value register always returns what software last wrote. Software sees the real pin level, including a level driven by another device, only through the read-only pad level register.

Every pin also has an interrupt detector. The detector can watch for a low level, a high level, a rising edge or a falling edge. A separate per-pin override bit makes it fire on both edges instead. A detected event sets a sticky flag, and software clears the flag by writing a one to it. A mask register selects which flags reach the two interrupt lines. One line collects pins 0 to 15 and the other collects pins 16 to 31.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset, every register reads zero, `pad_oe` is all zeros, and both interrupt lines are low.
- R2: The register select is a word index: 0 value, 1 output enable, 2 pad level (read-only), 3 trigger word for pins 0–15, 4 trigger word for pins 16–31, 5 mask, 6 flags, 7 both-edge override. A write to any index other than 2 stores `reg_wdata` on that clock edge. Reads are combinational.
- R3: The value register reads back the last value written to it. `pad_out` equals the value register, and `pad_oe` equals the output-enable register.
- R4: Pad level (index 2) returns `pad_in` as it was two clocks earlier, delayed through a two-stage synchroniser. Writes to index 2 change nothing.
- R5: The trigger code of pin n sits in bits [2n+1:2n] of word 3 when n < 16, and in bits [2(n−16)+1:2(n−16)] of word 4 otherwise. The codes are 0 = low level, 1 = high level, 2 = rising edge, 3 = falling edge.
- R6: An edge is detected when the synchronised level differs from its value one clock earlier. The flag is set on the clock after that synchronised change.
- R7: In a level mode, the flag is set again on every clock in which the condition holds.
- R8: When a pin's both-edge override bit is 1, its flag is set on either edge, and its trigger code is ignored.
- R9: Writing to index 6 clears each flag whose write bit is 1 and leaves the others unchanged. If a set and a clear hit the same flag on the same clock, the set wins.
- R10: `irq_lo` is the OR over pins 0–15 of flag AND mask. `irq_hi` is the same OR over pins 16–31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register word index |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_sel` |
| pad_in | input | 32 | Raw pin levels |
| pad_out | output | 32 | Output value per pin |
| pad_oe | output | 32 | Output enable per pin (1 = drive) |
| irq_lo | output | 1 | Interrupt line for pins 0–15 |
| irq_hi | output | 1 | Interrupt line for pins 16–31 |

## Verification
A wrong trigger decode, a misplaced field or a broken override shows up as a flag read at index 6. A bad flag or mask also shows up on an interrupt line, on the first clock after the synchronised pin change. A synchroniser of the wrong depth moves the pad level read and every flag set by one clock, so a comparison made each cycle catches it at once. A flag that a clear fails to drop, or one that drops without a clear, stays visible until the next write to index 6.

// File: rtl/gpioc_pkg.sv
package gpioc_pkg;

    localparam int SEL_W = 3;

    typedef enum logic [SEL_W-1:0] {
        SEL_VALUE  = 3'd0,
        SEL_OE     = 3'd1,
        SEL_LEVEL  = 3'd2,
        SEL_TRG_LO = 3'd3,
        SEL_TRG_HI = 3'd4,
        SEL_MASK   = 3'd5,
        SEL_FLAGS  = 3'd6,
        SEL_BOTH   = 3'd7
    } sel_e;

    typedef enum logic [1:0] {
        TRG_LOW  = 2'd0,
        TRG_HIGH = 2'd1,
        TRG_RISE = 2'd2,
        TRG_FALL = 2'd3
    } trig_e;

    // Detector for a single pin: current and previous synchronised level.
    function automatic logic pin_event(trig_e code, logic both, logic cur, logic prv);
        logic hit;
        if (both) begin
            hit = cur ^ prv;
        end else begin
            unique case (code)
                TRG_LOW:  hit = ~cur;
                TRG_HIGH: hit = cur;
                TRG_RISE: hit = cur & ~prv;
                TRG_FALL: hit = ~cur & prv;
                default:  hit = 1'b0;
            endcase
        end
        return hit;
    endfunction

endpackage

// File: rtl/gpioc_sync.sv
module gpioc_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] raw,
    output logic [W-1:0] lvl,
    output logic [W-1:0] lvl_prev
);
    logic [W-1:0] meta_q;
    logic [W-1:0] lvl_q;
    logic [W-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            lvl_q  <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= raw;
            lvl_q  <= meta_q;
            prev_q <= lvl_q;
        end
    end

    assign lvl      = lvl_q;
    assign lvl_prev = prev_q;
endmodule

// File: rtl/gpioc_detect.sv
module gpioc_detect
    import gpioc_pkg::*;
#(
    parameter int N = 32
) (
    input  logic [2*N-1:0] trg_codes,
    input  logic [N-1:0]   both_sel,
    input  logic [N-1:0]   lvl,
    input  logic [N-1:0]   lvl_prev,
    output logic [N-1:0]   hit
);
    for (genvar p = 0; p < N; p++) begin : g_pin
        assign hit[p] = pin_event(trig_e'(trg_codes[2*p +: 2]), both_sel[p],
                                  lvl[p], lvl_prev[p]);
    end
endmodule

// File: rtl/gpioc_regs.sv
module gpioc_regs
    import gpioc_pkg::*;
#(
    parameter int N = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [SEL_W-1:0] sel,
    input  logic [N-1:0]     wdata,
    input  logic [N-1:0]     clr_vec,
    input  logic [N-1:0]     set_vec,
    input  logic [N-1:0]     lvl,
    output logic [N-1:0]     rdata,
    output logic [N-1:0]     value_q,
    output logic [N-1:0]     oe_q,
    output logic [2*N-1:0]   trg_q,
    output logic [N-1:0]     both_q,
    output logic [N-1:0]     mask_q,
    output logic [N-1:0]     flags_q
);
    localparam int HALF_W = N;   // each trigger word holds N/2 two-bit codes

    sel_e sel_e_w;
    assign sel_e_w = sel_e'(sel);

    always_ff @(posedge clk) begin
        if (rst) begin
            value_q <= '0;
            oe_q    <= '0;
            trg_q   <= '0;
            both_q  <= '0;
            mask_q  <= '0;
        end else if (we) begin
            unique case (sel_e_w)
                SEL_VALUE:  value_q <= wdata;
                SEL_OE:     oe_q    <= wdata;
                SEL_TRG_LO: trg_q[HALF_W-1:0]        <= wdata;
                SEL_TRG_HI: trg_q[2*HALF_W-1:HALF_W] <= wdata;
                SEL_MASK:   mask_q  <= wdata;
                SEL_BOTH:   both_q  <= wdata;
                default:    ;
            endcase
        end
    end

    // Sticky flags: the set term is applied after the clear, so it wins.
    always_ff @(posedge clk) begin
        if (rst) flags_q <= '0;
        else     flags_q <= (flags_q & ~clr_vec) | set_vec;
    end

    always_comb begin
        unique case (sel_e_w)
            SEL_VALUE:  rdata = value_q;
            SEL_OE:     rdata = oe_q;
            SEL_LEVEL:  rdata = lvl;
            SEL_TRG_LO: rdata = trg_q[HALF_W-1:0];
            SEL_TRG_HI: rdata = trg_q[2*HALF_W-1:HALF_W];
            SEL_MASK:   rdata = mask_q;
            SEL_FLAGS:  rdata = flags_q;
            SEL_BOTH:   rdata = both_q;
            default:    rdata = '0;
        endcase
    end
endmodule

// File: rtl/gpioc_irq_merge.sv
module gpioc_irq_merge #(
    parameter int N     = 32,
    parameter int LINES = 2
) (
    input  logic [N-1:0]     flags,
    input  logic [N-1:0]     mask,
    output logic [LINES-1:0] irq
);
    localparam int PER_LINE = N / LINES;

    logic [N-1:0] pend;
    assign pend = flags & mask;

    for (genvar l = 0; l < LINES; l++) begin : g_line
        assign irq[l] = |pend[l*PER_LINE +: PER_LINE];
    end
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
    import gpioc_pkg::*;
#(
    parameter int NPINS = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_we,
    input  logic [2:0]       reg_sel,
    input  logic [NPINS-1:0] reg_wdata,
    output logic [NPINS-1:0] reg_rdata,
    input  logic [NPINS-1:0] pad_in,
    output logic [NPINS-1:0] pad_out,
    output logic [NPINS-1:0] pad_oe,
    output logic             irq_lo,
    output logic             irq_hi
);
    localparam int LINES = 2;

    logic [NPINS-1:0]   lvl, lvl_prev;
    logic [NPINS-1:0]   set_vec, clr_vec;
    logic [NPINS-1:0]   value_q, oe_q, both_q, mask_q, status_q;
    logic [2*NPINS-1:0] trg_q;
    logic [LINES-1:0]   irq_w;

    assign clr_vec = (reg_we && sel_e'(reg_sel) == SEL_FLAGS) ? reg_wdata : '0;

    gpioc_sync #(.W(NPINS)) u_sync (
        .clk(clk), .rst(rst), .raw(pad_in), .lvl(lvl), .lvl_prev(lvl_prev)
    );

    gpioc_detect #(.N(NPINS)) u_detect (
        .trg_codes(trg_q), .both_sel(both_q), .lvl(lvl), .lvl_prev(lvl_prev),
        .hit(set_vec)
    );

    gpioc_regs #(.N(NPINS)) u_regs (
        .clk(clk), .rst(rst), .we(reg_we), .sel(reg_sel), .wdata(reg_wdata),
        .clr_vec(clr_vec), .set_vec(set_vec), .lvl(lvl), .rdata(reg_rdata),
        .value_q(value_q), .oe_q(oe_q), .trg_q(trg_q), .both_q(both_q),
        .mask_q(mask_q), .flags_q(status_q)
    );

    gpioc_irq_merge #(.N(NPINS), .LINES(LINES)) u_irq (
        .flags(status_q), .mask(mask_q), .irq(irq_w)
    );

    assign pad_out = value_q;
    assign pad_oe  = oe_q;
    assign irq_lo  = irq_w[0];
    assign irq_hi  = irq_w[1];
endmodule

// File: rtl/gpioc_chk.sv
module gpioc_chk #(
    parameter int NPINS = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             reg_we,
    input logic [2:0]       reg_sel,
    input logic [NPINS-1:0] reg_wdata,
    input logic [NPINS-1:0] pad_out,
    input logic             irq_lo,
    input logic             irq_hi,
    input logic [NPINS-1:0] status_q,
    input logic [NPINS-1:0] mask_q,
    input logic [NPINS-1:0] set_vec,
    input logic [NPINS-1:0] clr_vec
);
    // R1
    mask_after_reset_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (mask_q == '0 && !irq_lo && !irq_hi));

    // R3
    value_to_pad_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_we && reg_sel == 3'd0) |=> (pad_out == $past(reg_wdata)));

    // R9
    clear_drops_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_vec != '0) |=> ((status_q & $past(clr_vec) & ~$past(set_vec)) == '0));

    // R9
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (set_vec != '0) |=> ((status_q & $past(set_vec)) == $past(set_vec)));

    // R9
    flags_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (($past(status_q) & ~$past(clr_vec) & ~status_q) == '0));

    // R10
    masked_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (mask_q == '0) |-> (!irq_lo && !irq_hi));
endmodule

bind gpio_irq_ctrl gpioc_chk #(.NPINS(NPINS)) u_gpioc_chk (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .pad_out(pad_out), .irq_lo(irq_lo), .irq_hi(irq_hi),
    .status_q(status_q), .mask_q(mask_q), .set_vec(set_vec), .clr_vec(clr_vec)
);

// File: tb/test_gpio_irq_ctrl.sv
`timescale 1ns/1ps
module test_gpio_irq_ctrl;
    localparam int N = 32;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         reg_we = 1'b0;
    logic [2:0]   reg_sel = 3'd0;
    logic [N-1:0] reg_wdata = '0;
    logic [N-1:0] reg_rdata;
    logic [N-1:0] pad_in = '0;
    logic [N-1:0] pad_out, pad_oe;
    logic         irq_lo, irq_hi;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    gpio_irq_ctrl #(.NPINS(N)) i_gpio_irq_ctrl (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .irq_lo(irq_lo), .irq_hi(irq_hi)
    );

    // Reference model built from the requirements.
    logic [N-1:0]   m_val, m_oe, m_both, m_mask, m_flags, m_s1, m_s2, m_prev;
    logic [2*N-1:0] m_trg;

    function automatic logic [N-1:0] ref_hits(logic [2*N-1:0] trg, logic [N-1:0] both,
                                              logic [N-1:0] cur, logic [N-1:0] prv);
        logic [N-1:0] h;
        for (int p = 0; p < N; p++) begin
            logic [1:0] c;
            c = trg[2*p +: 2];
            if (both[p])      h[p] = cur[p] != prv[p];
            else if (c == 0)  h[p] = !cur[p];
            else if (c == 1)  h[p] = cur[p];
            else if (c == 2)  h[p] = cur[p] && !prv[p];
            else              h[p] = !cur[p] && prv[p];
        end
        return h;
    endfunction

    function automatic logic [N-1:0] ref_read(logic [2:0] s);
        case (s)
            3'd0: return m_val;
            3'd1: return m_oe;
            3'd2: return m_s2;
            3'd3: return m_trg[N-1:0];
            3'd4: return m_trg[2*N-1:N];
            3'd5: return m_mask;
            3'd6: return m_flags;
            default: return m_both;
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_val <= '0; m_oe <= '0; m_both <= '0; m_mask <= '0; m_flags <= '0;
            m_s1 <= '0; m_s2 <= '0; m_prev <= '0; m_trg <= '0;
        end else begin
            m_s1   <= pad_in;
            m_s2   <= m_s1;
            m_prev <= m_s2;
            m_flags <= (m_flags & ~((reg_we && reg_sel == 3'd6) ? reg_wdata : '0))
                       | ref_hits(m_trg, m_both, m_s2, m_prev);
            if (reg_we) begin
                case (reg_sel)
                    3'd0: m_val <= reg_wdata;
                    3'd1: m_oe <= reg_wdata;
                    3'd3: m_trg[N-1:0] <= reg_wdata;
                    3'd4: m_trg[2*N-1:N] <= reg_wdata;
                    3'd5: m_mask <= reg_wdata;
                    3'd7: m_both <= reg_wdata;
                    default: ;
                endcase
            end
        end
    end

    task automatic check(string tag, logic [N-1:0] act, logic [N-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Read one register and compare it, plus the pins and interrupt lines.
    task automatic rd_chk(logic [2:0] s, string tag);
        @(negedge clk);
        reg_we  = 1'b0;
        reg_sel = s;
        #1;
        check(tag, reg_rdata, ref_read(s));
        check("R3 pad_out", pad_out, m_val);
        check("R3 pad_oe", pad_oe, m_oe);
        check("R10 irq_lo", {31'd0, irq_lo}, {31'd0, |(m_flags[15:0] & m_mask[15:0])});
        check("R10 irq_hi", {31'd0, irq_hi}, {31'd0, |(m_flags[31:16] & m_mask[31:16])});
    endtask

    task automatic wr(logic [2:0] s, logic [N-1:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_sel = s; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic pads(logic [N-1:0] v);
        @(negedge clk);
        pad_in = v;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [N-1:0] r;
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        #1;
        // R1: literal reset values for the control registers and the outputs
        check("R1 irq", {30'd0, irq_hi, irq_lo}, '0);
        check("R1 pad_oe", pad_oe, '0);
        for (int s = 0; s < 8; s++) begin
            if (s != 6 && s != 2) begin
                reg_sel = 3'(s); #1;
                check("R1 reg", reg_rdata, '0);
            end
        end

        // R2 / R3: value readback is independent of the pad level
        wr(3'd0, 32'hA5A5_0F0F);
        wr(3'd1, 32'hFFFF_0000);
        pads(32'h1234_5678);
        idle(3);
        rd_chk(3'd0, "R3 value readback");
        rd_chk(3'd2, "R4 pad level");
        check("R3 literal", reg_rdata == 32'h1234_5678 ? pad_out : '0, 32'hA5A5_0F0F);
        // R4: a write to the pad level register changes nothing
        wr(3'd2, 32'hFFFF_FFFF);
        rd_chk(3'd2, "R4 write ignored");

        // R4 timing: the new level shows after exactly two clocks
        pads(32'h0000_0001);
        rd_chk(3'd2, "R4 one clock");
        rd_chk(3'd2, "R4 two clocks");

        // R5/R6: pin 5 rising (word 3, bits 11:10), pin 20 falling (word 4, bits 9:8)
        wr(3'd3, 32'h0000_0800 | 32'h5555_0000);
        wr(3'd4, 32'h0000_0300);
        pads(32'h0010_0000);
        idle(4);
        wr(3'd6, 32'hFFFF_FFFF);
        rd_chk(3'd6, "R5 cleared");
        pads(32'h0000_0020);
        idle(4);
        rd_chk(3'd6, "R6 rise pin5 fall pin20");
        check("R6 literal", reg_rdata & 32'h0010_0020, 32'h0010_0020);

        // R9: clear removes an edge flag; zeros leave others
        wr(3'd6, 32'h0000_0020);
        rd_chk(3'd6, "R9 w1c");
        check("R9 pin5 clear", reg_rdata & 32'h20, '0);

        // R7: high level on pin 5 keeps re-setting; clear has no lasting effect
        wr(3'd3, 32'h0000_0400);
        idle(2);
        wr(3'd6, 32'h0000_0020);
        rd_chk(3'd6, "R7 level reasserts");
        check("R7 literal", reg_rdata & 32'h20, 32'h20);

        // R8: both-edge override on pin 9 with a high-level code
        wr(3'd3, 32'h0004_0000);
        wr(3'd7, 32'h0000_0200);
        wr(3'd6, 32'hFFFF_FFFF);
        rd_chk(3'd6, "R8 quiet");
        pads(32'h0000_0220);
        idle(4);
        wr(3'd6, 32'h0000_0200);
        rd_chk(3'd6, "R8 cleared after rise");
        pads(32'h0000_0020);
        idle(4);
        rd_chk(3'd6, "R8 fall detected");

        // R10: mask routes flags to the two lines
        wr(3'd5, 32'h0000_0200);
        rd_chk(3'd5, "R10 mask low half");
        wr(3'd5, 32'hFFFF_0000);
        rd_chk(3'd5, "R10 mask high half");

        // Constrained random traffic
        for (int it = 0; it < 4000; it++) begin
            int op;
            op = int'($urandom_range(0, 9));
            if (op < 4) begin
                r = pad_in ^ ($urandom() & $urandom() & $urandom());
                pads(r);
            end else if (op < 7) begin
                wr(3'($urandom_range(0, 7)), $urandom());
            end else if (op < 9) begin
                wr(3'd6, $urandom() & $urandom());
            end else begin
                idle(int'($urandom_range(1, 3)));
            end
            rd_chk(3'($urandom_range(0, 7)), "R2 R5 R6 R7 R8 R9 random");
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule